// File: doc/BRIEF.md
# Bitfield Extract and Insert Unit

This unit does the bitfield work of a small command processor's ALU. Each cycle it takes two 32-bit operands (A and B), a 3-bit operation code, and three 5-bit fields decoded from the instruction word: a source bit position, a field size and a destination bit position. It produces a registered 32-bit result and an invalid flag one clock edge later.

It supports three operations:

- **Insert.** A field is cut from B and merged into a copy of A.
- **Extract with register position.** A field is read from B at a position held in A, then moved left by the immediate destination position.
- **Extract with register shift.** A field is read from B at the immediate source position, then moved left by an amount held in A.

All three use the same pair of datapath stages: a right shift followed by a mask, then a left shift merged into a base word. Only the shift amounts and the base word change with the operation. Register access and instruction sequencing happen outside the block.

Top module: `bfx_unit`

## Requirements
- R1: While rst_ni is low, result_o is 0 and invalid_o is 0, whatever the inputs are.
- R2: result_o and invalid_o change only at a rising clock edge. They show the function of the inputs sampled at the previous edge, so the latency is one cycle.
- R3: The field mask has its lowest size_i bits set and all other bits clear, which equals 2^size_i - 1. Operation 3 with A = 0, destination 0 and B all ones gives exactly this mask.
- R4: Operation code 2 (insert) works as follows. The field is B shifted right by src_pos_i and masked. The result is A with the mask-wide region starting at bit dst_pos_i cleared, then ORed with the field shifted left by dst_pos_i.
- R5: Operation code 3 gives B shifted right by A[4:0], masked, then shifted left by dst_pos_i.
- R6: Operation code 4 gives B shifted right by src_pos_i, masked, then shifted left by A[4:0].
- R7: With size_i = 0 the mask is empty. Insert then returns A unchanged, and operations 3 and 4 return 0.
- R8: A shift or position taken from A uses only A[4:0]. Bits 31:5 of A have no effect on that amount.
- R9: Bits moved above bit 31 by any left shift are dropped. Bits above bit 31 of B never enter the field; they read as 0.
- R10: Any operation code other than 2, 3 or 4 gives result 0 with invalid_o set. Codes 2, 3 and 4 give invalid_o clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code (2 insert, 3 extract with register position, 4 extract with register shift) |
| a_i | input | 32 | Operand A: insert base, or register position/shift |
| b_i | input | 32 | Operand B: field source |
| src_pos_i | input | 5 | Immediate source bit position (instruction bits 21:17) |
| size_i | input | 5 | Field size in bits (instruction bits 26:22) |
| dst_pos_i | input | 5 | Immediate destination bit position (instruction bits 31:27) |
| result_o | output | 32 | Registered result |
| invalid_o | output | 1 | Registered flag for an unsupported operation code |

## Verification
Every result and invalid flag is due at the first rising edge after its inputs are applied, with no other delay. The bench drives inputs at a falling edge and compares the outputs at the next falling edge, half a period after the capturing edge. To prove that nothing passes through combinationally, one check changes the inputs between edges and confirms that the outputs still hold the earlier value. The bench's reference model builds each field bit by bit from the requirements.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  localparam int OP_W = 3;
  localparam logic [OP_W-1:0] OP_INSERT   = 3'd2;
  localparam logic [OP_W-1:0] OP_EXT_RPOS = 3'd3; // position from A, immediate shift
  localparam logic [OP_W-1:0] OP_EXT_RSHL = 3'd4; // immediate position, shift from A
endpackage

// File: rtl/bfx_mask_gen.sv
module bfx_mask_gen #(
  parameter int DATA_W = 32,
  parameter int POS_W  = $clog2(DATA_W)
) (
  input  logic [POS_W-1:0]  size_i,
  output logic [DATA_W-1:0] mask_o
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    localparam logic [POS_W:0] IDX = (POS_W+1)'(g);
    assign mask_o[g] = IDX < {1'b0, size_i};
  end
endmodule

// File: rtl/bfx_extract.sv
module bfx_extract #(
  parameter int DATA_W = 32,
  parameter int POS_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [POS_W-1:0]  shamt_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] field_o
);
  assign field_o = (data_i >> shamt_i) & mask_i;
endmodule

// File: rtl/bfx_place.sv
module bfx_place #(
  parameter int DATA_W = 32,
  parameter int POS_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] field_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [POS_W-1:0]  shamt_i,
  output logic [DATA_W-1:0] merged_o
);
  logic [DATA_W-1:0] hole;
  assign hole     = mask_i << shamt_i;
  assign merged_o = (base_i & ~hole) | (field_i << shamt_i);
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int POS_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [POS_W-1:0]  src_pos_i,
  input  logic [POS_W-1:0]  size_i,
  input  logic [POS_W-1:0]  dst_pos_i,
  output logic [DATA_W-1:0] result_o,
  output logic              invalid_o
);
  logic [DATA_W-1:0] mask, field, base, merged;
  logic [POS_W-1:0]  ext_shamt, put_shamt;
  logic              op_ok;

  assign op_ok     = (op_i == OP_INSERT) || (op_i == OP_EXT_RPOS) || (op_i == OP_EXT_RSHL);
  assign ext_shamt = (op_i == OP_EXT_RPOS) ? a_i[POS_W-1:0] : src_pos_i;
  assign put_shamt = (op_i == OP_EXT_RSHL) ? a_i[POS_W-1:0] : dst_pos_i;
  // extracts merge into an empty word, insert merges into A
  assign base      = (op_i == OP_INSERT) ? a_i : '0;

  bfx_mask_gen #(.DATA_W(DATA_W), .POS_W(POS_W)) i_mask (
    .size_i (size_i),
    .mask_o (mask)
  );

  bfx_extract #(.DATA_W(DATA_W), .POS_W(POS_W)) i_extract (
    .data_i  (b_i),
    .shamt_i (ext_shamt),
    .mask_i  (mask),
    .field_o (field)
  );

  bfx_place #(.DATA_W(DATA_W), .POS_W(POS_W)) i_place (
    .base_i   (base),
    .field_i  (field),
    .mask_i   (mask),
    .shamt_i  (put_shamt),
    .merged_o (merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      invalid_o <= 1'b0;
    end else begin
      result_o  <= op_ok ? merged : '0;
      invalid_o <= !op_ok;
    end
  end
endmodule

// File: rtl/bfx_unit_chk.sv
module bfx_unit_chk #(
  parameter int DATA_W = 32,
  parameter int POS_W  = $clog2(DATA_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [POS_W-1:0]  size_i,
  input logic [POS_W-1:0]  dst_pos_i,
  input logic [DATA_W-1:0] result_o,
  input logic              invalid_o
);
  logic is_ins, is_ext, is_known;
  logic [DATA_W-1:0] chk_region;

  assign is_ins   = (op_i == 3'd2);
  assign is_ext   = (op_i == 3'd3) || (op_i == 3'd4);
  assign is_known = is_ins || is_ext;

  always_comb begin
    chk_region = '0;
    for (int i = 0; i < DATA_W; i++)
      if (i < int'(size_i) && (i + int'(dst_pos_i)) < DATA_W)
        chk_region[i + int'(dst_pos_i)] = 1'b1;
  end

  always @(posedge clk_i)
    if (!rst_ni) p_reset_r1: assert (result_o == '0 && !invalid_o);

  p_bad_op_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_known |=> (invalid_o && result_o == '0));

  p_good_op_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_known |=> !invalid_o);

  p_empty_ext_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ext && size_i == '0) |=> result_o == '0);

  p_empty_ins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ins && size_i == '0) |=> result_o == $past(a_i));

  p_ext_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ext |=> $countones(result_o) <= int'($past(size_i)));

  p_ins_outside_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ins |=> ((result_o ^ $past(a_i)) & ~$past(chk_region)) == '0);
endmodule

bind bfx_unit bfx_unit_chk #(.DATA_W(DATA_W), .POS_W(POS_W)) i_bfx_unit_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .op_i      (op_i),
  .a_i       (a_i),
  .size_i    (size_i),
  .dst_pos_i (dst_pos_i),
  .result_o  (result_o),
  .invalid_o (invalid_o)
);

// File: tb/test_bfx_unit.sv
module test_bfx_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [4:0]  src_pos_i = '0, size_i = '0, dst_pos_i = '0;
  logic [31:0] result_o;
  logic        invalid_o;

  int total = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bfx_unit i_bfx_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .src_pos_i(src_pos_i), .size_i(size_i), .dst_pos_i(dst_pos_i),
    .result_o(result_o), .invalid_o(invalid_o)
  );

  function automatic logic [31:0] ref_result(input logic [2:0] op, input logic [31:0] a,
      input logic [31:0] b, input int sp, input int sz, input int dp);
    logic [31:0] fld, r;
    int pos, shl;
    if (op != 3'd2 && op != 3'd3 && op != 3'd4) return 32'h0;
    pos = (op == 3'd3) ? int'(a % 32) : sp;
    shl = (op == 3'd4) ? int'(a % 32) : dp;
    fld = '0;
    for (int i = 0; i < sz; i++) if (pos + i < 32) fld[i] = b[pos + i];
    r = (op == 3'd2) ? a : 32'h0;
    for (int i = 0; i < sz; i++) if (shl + i < 32) r[shl + i] = fld[i];
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       input int sp, input int sz, input int dp);
    op_i = op; a_i = a; b_i = b;
    src_pos_i = 5'(sp); size_i = 5'(sz); dst_pos_i = 5'(dp);
  endtask

  // drive at a falling edge, compare at the next falling edge
  task automatic apply(input string tag, input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] b, input int sp, input int sz, input int dp);
    logic [31:0] exp;
    logic        bad;
    drive(op, a, b, sp, sz, dp);
    exp = ref_result(op, a, b, sp, sz, dp);
    bad = !(op == 3'd2 || op == 3'd3 || op == 3'd4);
    @(negedge clk_i);
    check(tag, result_o, exp);
    check({tag, " invalid (R10)"}, {31'b0, invalid_o}, {31'b0, bad});
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int pts[7] = '{0, 1, 5, 13, 20, 27, 31};
    logic [31:0] hold;
    // R1: reset holds outputs low even with a valid op applied
    drive(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 8, 0);
    repeat (3) @(negedge clk_i);
    check("R1 result in reset", result_o, 32'h0);
    check("R1 invalid in reset", {31'b0, invalid_o}, 32'h0);
    drive(3'd7, 32'h0, 32'h0, 0, 0, 0);
    @(negedge clk_i);
    check("R1 invalid in reset bad op", {31'b0, invalid_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3: mask shape for every size
    for (int s = 0; s < 32; s++)
      apply("R3 mask", 3'd3, 32'h0, 32'hFFFF_FFFF, 0, s, 0);

    // R2: an input change between edges leaves outputs untouched
    apply("R2 first", 3'd2, 32'h1234_5678, 32'h0000_00AB, 0, 8, 4);
    hold = result_o;
    drive(3'd4, 32'h3, 32'hFFFF_FFFF, 0, 16, 0);
    #(CLK_PERIOD/4);
    check("R2 held between edges", result_o, hold);
    @(negedge clk_i);
    check("R2 next edge", result_o, 32'h0007_FFF8);

    // R8: upper bits of A ignored for register amounts
    apply("R8 reg pos", 3'd3, 32'hFFFF_FFE4, 32'h0000_00F0, 0, 4, 0);
    check("R8 reg pos value", result_o, 32'h0000_000F);
    apply("R8 reg shl", 3'd4, 32'hABCD_EF02, 32'h0000_0005, 0, 3, 0);
    check("R8 reg shl value", result_o, 32'h0000_0014);

    // R9: bits pushed beyond bit 31 vanish
    apply("R9 shl top", 3'd4, 32'd31, 32'h0000_00FF, 0, 8, 0);
    check("R9 shl top value", result_o, 32'h8000_0000);
    apply("R9 ins top", 3'd2, 32'h0000_0000, 32'hFFFF_FFFF, 0, 8, 28);
    check("R9 ins top value", result_o, 32'hF000_0000);
    apply("R9 read past top", 3'd3, 32'd30, 32'hC000_0000, 0, 8, 0);
    check("R9 read past top value", result_o, 32'h0000_0003);

    // R7: empty mask
    apply("R7 ins size0", 3'd2, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 3, 0, 9);
    check("R7 ins size0 value", result_o, 32'hDEAD_BEEF);

    // sweep: every op code, every size, a grid of positions
    for (int op = 0; op < 8; op++)
      for (int s = 0; s < 32; s++)
        for (int pi = 0; pi < 7; pi++)
          for (int qi = 0; qi < 7; qi++) begin
            logic [31:0] k, a, b;
            string tag;
            k = 32'(op * 1568 + s * 49 + pi * 7 + qi);
            a = 32'hA5C3_1E7F ^ (k * 32'h9E37_79B9);
            b = 32'h3C6E_F372 + (k * 32'h6A09_E667);
            case (op)
              2: tag = (s == 0) ? "R7 insert" : "R4 insert";
              3: tag = (s == 0) ? "R7 ext reg pos" : "R5 ext reg pos";
              4: tag = (s == 0) ? "R7 ext reg shl" : "R6 ext reg shl";
              default: tag = "R10 bad op";
            endcase
            apply(tag, 3'(op), a, b, pts[pi], s, pts[qi]);
          end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule